// File: doc/BRIEF.md
# Vector Step Control and Status Unit

This unit executes a step-and-query instruction on behalf of a vector loop sequencer. The loop state (vector length, sub-vector length, the source and destination element indices, the source and destination sub-element indices) is held in an external state register and presented on input ports. Each instruction carries a 7-bit selector, a stepping bit and a condition-record bit. Depending on the selector, the unit does one of three things:

- returns one loop index or one of four externally computed shape offsets on a result bus;
- rewrites the packing/unpacking ordering flags;
- requests one advance from the external source iterator and then one from the destination iterator.

The unit also evaluates whether the loop has reached its final element. When the condition-record bit is set, it reports this as the equality bit of condition field 0. When the stepping bit is clear, the instruction is a pure enquiry and no state-changing request leaves the unit. All responses are registered and appear on the clock edge that follows the instruction strobe. The destination iterator request follows one cycle after the source iterator request.

Top module: `vstep_ctrl`

## Requirements
- R1: Selectors 1, 2, 3 and 4 return shape offsets 0, 1, 2 and 3, zero-extended on `res_data`.
- R2: Selectors 5, 6, 7 and 8 return the source index, destination index, source sub-index and destination sub-index respectively, each zero-extended.
- R3: With the stepping bit at 1, selector 12 (0b1100) drives `mode_we` with both `mode_pack` and `mode_unpack` at 0. Selector 13 (0b1101) gives pack 1 and unpack 0. Selector 14 (0b1110) gives pack 0 and unpack 1. The result data is 0.
- R4: Selector 0 with the stepping bit at 1 pulses `src_step` on the edge after the strobe and `dst_step` on the following edge, and returns 0.
- R5: With the stepping bit at 0, no selector produces `mode_we`, `src_step` or `dst_step`, while queries are still answered.
- R6: Selector 0 with the stepping bit at 0 and the condition-record bit at 0 produces no output activity at all: `res_valid`, `cr_we`, `mode_we` and both step strobes stay 0.
- R7: Loop end is true when the source index equals VL-1 and the source sub-index equals the sub-length field, or when the destination index equals VL-1 and the destination sub-index equals the sub-length field. The sub-length field is coded as element count minus one.
- R8: When the condition-record bit is 1, `cr_we` pulses with the response, and `cr0_eq` carries the loop-end value of the state present at the strobe. When that bit is 0, both `cr_we` and `cr0_eq` stay 0.
- R9: Selectors not listed above (9 to 11, 15 to 127) return 0 and raise neither `mode_we` nor a step strobe.
- R10: Every response (`res_valid`, `res_data`, `cr_we`, `cr0_eq`, `mode_we`, `src_step`) is a single-cycle pulse registered on the edge after `ins_valid`. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction strobe, one cycle per instruction |
| ins_sel | input | 7 | Selector field |
| ins_vf | input | 1 | Stepping bit (0 = enquiry only) |
| ins_rc | input | 1 | Condition-record bit |
| st_vl | input | VLW+1 | Vector length (element count) |
| st_subvl | input | SUBW | Sub-vector length minus one |
| st_srcstep | input | VLW | Source element index |
| st_dststep | input | VLW | Destination element index |
| st_ssub | input | SUBW | Source sub-element index |
| st_dsub | input | SUBW | Destination sub-element index |
| shape_off0 | input | OFFW | Current offset of shape unit 0 |
| shape_off1 | input | OFFW | Current offset of shape unit 1 |
| shape_off2 | input | OFFW | Current offset of shape unit 2 |
| shape_off3 | input | OFFW | Current offset of shape unit 3 |
| res_valid | output | 1 | Result write pulse |
| res_data | output | XLEN | Result value |
| cr_we | output | 1 | Condition field write pulse |
| cr0_eq | output | 1 | Equality bit of condition field 0 (loop end) |
| mode_we | output | 1 | Ordering-flag write pulse |
| mode_pack | output | 1 | New pack flag |
| mode_unpack | output | 1 | New unpack flag |
| src_step | output | 1 | Source iterator advance request |
| dst_step | output | 1 | Destination iterator advance request |

## Verification
A selector decode fault appears on the edge after the strobe, as a wrong value on `res_data` or as a stray `mode_we` or step pulse. An enquiry-mode leak is visible as a state-change request even though the stepping bit was 0. A faulty loop-end comparison appears in the same cycle as a wrong `cr0_eq`. A broken step sequence shows up one cycle later, as a missing or misplaced `dst_step`.

// File: rtl/vstep_ctrl.sv
module vstep_ctrl #(
  parameter int XLEN = 64,
  parameter int VLW  = 7,
  parameter int SUBW = 2,
  parameter int OFFW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [6:0]      ins_sel,
  input  logic            ins_vf,
  input  logic            ins_rc,
  input  logic [VLW:0]    st_vl,
  input  logic [SUBW-1:0] st_subvl,
  input  logic [VLW-1:0]  st_srcstep,
  input  logic [VLW-1:0]  st_dststep,
  input  logic [SUBW-1:0] st_ssub,
  input  logic [SUBW-1:0] st_dsub,
  input  logic [OFFW-1:0] shape_off0,
  input  logic [OFFW-1:0] shape_off1,
  input  logic [OFFW-1:0] shape_off2,
  input  logic [OFFW-1:0] shape_off3,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            cr_we,
  output logic            cr0_eq,
  output logic            mode_we,
  output logic            mode_pack,
  output logic            mode_unpack,
  output logic            src_step,
  output logic            dst_step
);

  localparam logic [6:0] SEL_STEP   = 7'd0;
  localparam logic [6:0] SEL_CLRPK  = 7'd12;
  localparam logic [6:0] SEL_SETPK  = 7'd13;
  localparam logic [6:0] SEL_SETUPK = 7'd14;

  logic [XLEN-1:0] q_data;
  logic [VLW:0]    vl_last;
  logic            loop_end, is_nop, is_mode, is_step;

  assign vl_last  = st_vl - 1'b1;
  assign loop_end = ({1'b0, st_srcstep} == vl_last && st_ssub == st_subvl) ||
                    ({1'b0, st_dststep} == vl_last && st_dsub == st_subvl);
  assign is_nop   = ins_sel == SEL_STEP && !ins_vf && !ins_rc;
  assign is_mode  = ins_vf && (ins_sel == SEL_CLRPK || ins_sel == SEL_SETPK ||
                               ins_sel == SEL_SETUPK);
  assign is_step  = ins_vf && ins_sel == SEL_STEP;

  always_comb begin
    q_data = '0;
    case (ins_sel)
      7'd1: q_data[OFFW-1:0] = shape_off0;
      7'd2: q_data[OFFW-1:0] = shape_off1;
      7'd3: q_data[OFFW-1:0] = shape_off2;
      7'd4: q_data[OFFW-1:0] = shape_off3;
      7'd5: q_data[VLW-1:0]  = st_srcstep;
      7'd6: q_data[VLW-1:0]  = st_dststep;
      7'd7: q_data[SUBW-1:0] = st_ssub;
      7'd8: q_data[SUBW-1:0] = st_dsub;
      default: q_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      cr_we       <= 1'b0;
      cr0_eq      <= 1'b0;
      mode_we     <= 1'b0;
      mode_pack   <= 1'b0;
      mode_unpack <= 1'b0;
      src_step    <= 1'b0;
      dst_step    <= 1'b0;
    end else begin
      res_valid   <= ins_valid && !is_nop;
      res_data    <= (ins_valid && !is_nop) ? q_data : '0;
      cr_we       <= ins_valid && ins_rc;
      cr0_eq      <= ins_valid && ins_rc && loop_end;
      mode_we     <= ins_valid && is_mode;
      mode_pack   <= ins_valid && is_mode && ins_sel == SEL_SETPK;
      mode_unpack <= ins_valid && is_mode && ins_sel == SEL_SETUPK;
      src_step    <= ins_valid && is_step;
      dst_step    <= src_step;
    end
  end

  a_r4_dst_after_src: assert property (@(posedge clk) disable iff (!rst_n)
    src_step |=> dst_step);
  a_r4_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
    src_step |-> res_valid && res_data == '0);
  a_r5_no_step_enquiry: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_vf |=> !mode_we && !src_step);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |-> !(mode_pack && mode_unpack));
  a_r8_eq_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_eq |-> cr_we);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> !res_valid && !cr_we && !mode_we && !src_step);
  a_r6_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_sel == 7'd0 && !ins_vf && !ins_rc |=> !res_valid && !cr_we);

endmodule

// File: tb/vstep_ctrl_tb.sv
module vstep_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_vf = 0, ins_rc = 0;
  logic [6:0] ins_sel = '0;
  logic [7:0] st_vl = 8'd4;
  logic [1:0] st_subvl = '0, st_ssub = '0, st_dsub = '0;
  logic [6:0] st_srcstep = '0, st_dststep = '0;
  logic [6:0] so0 = 7'h11, so1 = 7'h22, so2 = 7'h33, so3 = 7'h44;
  logic res_valid, cr_we, cr0_eq, mode_we, mode_pack, mode_unpack, src_step, dst_step;
  logic [63:0] res_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vstep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_sel(ins_sel),
    .ins_vf(ins_vf), .ins_rc(ins_rc), .st_vl(st_vl), .st_subvl(st_subvl),
    .st_srcstep(st_srcstep), .st_dststep(st_dststep), .st_ssub(st_ssub),
    .st_dsub(st_dsub), .shape_off0(so0), .shape_off1(so1), .shape_off2(so2),
    .shape_off3(so3), .res_valid(res_valid), .res_data(res_data), .cr_we(cr_we),
    .cr0_eq(cr0_eq), .mode_we(mode_we), .mode_pack(mode_pack),
    .mode_unpack(mode_unpack), .src_step(src_step), .dst_step(dst_step));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (after one posedge)
  task automatic issue(input logic [6:0] sel, input logic vf, input logic rc);
    @(negedge clk);
    ins_sel = sel; ins_vf = vf; ins_rc = rc; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", res_valid, 0);
    chk("R10 reset res_data", res_data, 0);
    chk("R10 reset strobes", {cr_we, cr0_eq, mode_we, mode_pack, mode_unpack, src_step, dst_step}, 0);
  endtask

  task automatic t_shape;
    issue(7'd1, 0, 0); chk("R1 sel1", res_data, 64'h11); chk("R1 valid", res_valid, 1);
    issue(7'd2, 0, 0); chk("R1 sel2", res_data, 64'h22);
    issue(7'd3, 1, 0); chk("R1 sel3", res_data, 64'h33);
    issue(7'd4, 0, 0); chk("R1 sel4", res_data, 64'h44);
    @(negedge clk); chk("R10 pulse ends", {res_valid, res_data != 0}, 0);
  endtask

  task automatic t_steps;
    st_srcstep = 7'd3; st_dststep = 7'd2; st_ssub = 2'd1; st_dsub = 2'd3;
    issue(7'd5, 0, 0); chk("R2 srcstep", res_data, 3);
    issue(7'd6, 0, 0); chk("R2 dststep", res_data, 2);
    issue(7'd7, 0, 0); chk("R2 ssubstep", res_data, 1);
    issue(7'd8, 1, 0); chk("R2 dsubstep", res_data, 3);
    st_srcstep = '0; st_dststep = '0; st_ssub = '0; st_dsub = '0;
  endtask

  task automatic t_mode;
    issue(7'd12, 1, 0); chk("R3 clear", {mode_we, mode_pack, mode_unpack}, 3'b100);
    chk("R3 data", res_data, 0);
    issue(7'd13, 1, 0); chk("R3 pack", {mode_we, mode_pack, mode_unpack}, 3'b110);
    issue(7'd14, 1, 0); chk("R3 unpack", {mode_we, mode_pack, mode_unpack}, 3'b101);
    @(negedge clk); chk("R10 mode pulse ends", mode_we, 0);
  endtask

  task automatic t_step;
    issue(7'd0, 1, 0);
    chk("R4 src_step", {src_step, dst_step}, 2'b10);
    chk("R4 result zero", {res_valid, res_data}, {1'b1, 64'h0});
    @(negedge clk);
    chk("R4 dst_step", {src_step, dst_step}, 2'b01);
    @(negedge clk);
    chk("R4 settle", {src_step, dst_step}, 2'b00);
  endtask

  task automatic t_enquiry;
    issue(7'd13, 0, 0); chk("R5 mode vf0", mode_we, 0);
    issue(7'd0, 0, 1); chk("R5 step vf0", src_step, 0);
    chk("R5 answered", res_valid, 1);
    @(negedge clk); chk("R5 no dst", dst_step, 0);
    issue(7'd5, 0, 0); chk("R5 query vf0", {res_valid, mode_we, src_step}, 3'b100);
  endtask

  task automatic t_nop;
    issue(7'd0, 0, 0);
    chk("R6 nop", {res_valid, cr_we, mode_we, src_step}, 0);
    @(negedge clk); chk("R6 nop dst", dst_step, 0);
  endtask

  task automatic t_loopend;
    st_vl = 8'd4; st_subvl = 2'd1;
    st_srcstep = 7'd3; st_ssub = 2'd1; st_dststep = 7'd0; st_dsub = 2'd0;
    issue(7'd5, 0, 1); chk("R7 src end", {cr_we, cr0_eq}, 2'b11);
    st_ssub = 2'd0;
    issue(7'd5, 0, 1); chk("R7 src sub not end", {cr_we, cr0_eq}, 2'b10);
    st_srcstep = 7'd1; st_dststep = 7'd3; st_dsub = 2'd1;
    issue(7'd6, 0, 1); chk("R7 dst end", cr0_eq, 1);
    issue(7'd6, 0, 0); chk("R8 rc0", {cr_we, cr0_eq}, 2'b00);
    st_vl = 8'd1; st_subvl = 2'd0; st_srcstep = 0; st_ssub = 0; st_dststep = 0; st_dsub = 2'd1;
    issue(7'd0, 1, 1); chk("R8 step rc1 end", {cr_we, cr0_eq}, 2'b11);
    st_vl = 8'd4; st_dsub = 0;
  endtask

  task automatic t_unlisted;
    issue(7'd9, 1, 0);   chk("R9 sel9", {res_data, mode_we, src_step}, 0);
    issue(7'd11, 1, 0);  chk("R9 sel11", {res_data, mode_we, src_step}, 0);
    issue(7'd15, 1, 0);  chk("R9 sel15", {res_data, mode_we, src_step}, 0);
    issue(7'd100, 1, 0); chk("R9 sel100", {res_data, mode_we, src_step}, 0);
    @(negedge clk); chk("R9 no dst", dst_step, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_shape();
    t_steps();
    t_mode();
    t_step();
    t_enquiry();
    t_nop();
    t_loopend();
    t_unlisted();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule